// File: doc/BRIEF.md
# Page Table Run Fill Engine

This engine fills a span of 64-bit page table entries in a word-addressed table memory. Each entry goes out as two 32-bit words on a write port that takes one word per cycle. A single command names the first entry, the number of entries, the operation and the entry attributes. The engine then produces every word itself and pulses a completion signal once the final word has been written.

The engine has three operations:

- **Contiguous map.** A physically contiguous region is mapped with 4 KiB or 64 KiB pages. The span is cut greedily into naturally aligned power-of-two runs of up to 128 entries. Every entry of a run holds the same value, and that value records the run size. When the memory type asks for compression, each run also gets a compression tag, derived from how far into the region the run starts.
- **Scatter map.** Entries are built one at a time from a stream of page frame numbers.
- **Unmap.** Every entry of the span is cleared.

Top module: `pte_run_filler`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle, and a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `done` is a single-cycle pulse that coincides with the strobe of the final word. A command with a count of zero writes nothing and raises `done` in the cycle right after it is taken.
- R2: Entry k is written as two strobes on consecutive cycles: the low word at byte address k*8, then the high word at k*8+4. Entries are written in ascending order.
- R3: A mapped entry has the following layout.
  - Low word: bit 0 is 1; bit 3 is the inverse of `cmd_wo`; bits 5:4 are the target; bit 6 is `cmd_sys`; bits 31:12 are physical address bits 31:12.
  - High word: bits 7:0 are physical address bits 39:32; bits 16:8 are the 9-bit memory type.
- R4: Contiguous map cuts the span greedily. At the current entry index it picks the largest n from 7 down to 0 such that 2^n fits in the remaining count and the index is a multiple of 2^n. The value n goes into low-word bits 9:7 of every entry of that run.
- R5: All entries of a run are identical. After each run, the physical address advances by the run length times the page size: 4 KiB when `cmd_page_big` is 0, 64 KiB when it is 1. The operation code `cmd_mode` is 0 for contiguous map, 1 for scatter and 2 for unmap.
- R6: In contiguous map, the compression factor f is memory type bits 8:7.
  - When f is nonzero, high-word bits 31:17 hold (`cmd_tag_base` + (offset >> 16) * f) mod 2^15. The offset starts at 0 and grows by run length times page size after each run.
  - When f is zero, those bits are 0.
- R7: In contiguous map, a nonzero `stolen_base` is added to the physical address and forces the target to 3. Otherwise the target is `cmd_target`.
- R8: Scatter map writes one entry for each accepted `sg_page` beat, with the physical address equal to `sg_page` * 4096. Bits 9:7 and bits 31:17 of the high word are 0. The target is 3 when `cmd_nosnoop` is set and 2 otherwise.
- R9: Unmap writes zero to both words of every entry in the span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_mode | input | 2 | 0 contiguous map, 1 scatter, 2 unmap |
| cmd_index | input | IDX_W | First entry index |
| cmd_count | input | CNT_W | Number of entries |
| cmd_phys | input | 40 | Physical byte base (contiguous map) |
| cmd_mtype | input | 9 | Memory type |
| cmd_target | input | 2 | Target for contiguous map |
| cmd_sys | input | 1 | System memory access flag |
| cmd_wo | input | 1 | Write-only mapping |
| cmd_nosnoop | input | 1 | No-snoop request (scatter) |
| cmd_page_big | input | 1 | 1 selects 64 KiB pages |
| cmd_tag_base | input | 15 | Compression tag base |
| stolen_base | input | 40 | Carve-out base, 0 when unused |
| sg_valid | input | 1 | Scatter frame offered |
| sg_ready | output | 1 | Engine takes a scatter frame |
| sg_page | input | 28 | Scatter page frame number (4 KiB units) |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | IDX_W+3 | Byte address of the word |
| wr_data | output | 32 | Word data |
| done | output | 1 | Command finished pulse |

## Verification
A run length chosen badly, or a remaining count that drifts, shows up on the write port almost at once. The run field is wrong within two cycles of the run's first strobe, and extra or missing strobes make `done` move away from the final word. A physical address or tag offset that advances wrongly stays hidden for the rest of the run. It becomes visible only on the first entry of the next run, so spans are chosen that cross several run boundaries at both page sizes. A target or flag latched wrongly corrupts the very first entry of the command.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
  localparam int PTF_PA_W    = 40;
  localparam int PTF_MT_W    = 9;
  localparam int PTF_TAG_W   = 15;
  localparam int PTF_RUN_MAX = 7;
  localparam int PTF_RUN_W   = 3;
  localparam int PTF_PG_W    = PTF_PA_W - 12;

  typedef enum logic [1:0] {
    PTF_MAP     = 2'd0,
    PTF_SCATTER = 2'd1,
    PTF_UNMAP   = 2'd2
  } ptf_mode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RUN  = 3'd1,
    S_SG   = 3'd2,
    S_LO   = 3'd3,
    S_HI   = 3'd4
  } ptf_state_e;
endpackage

// File: rtl/ptf_run_sizer.sv
module ptf_run_sizer #(
  parameter int IDX_W   = 16,
  parameter int CNT_W   = 16,
  parameter int RUN_MAX = 7,
  parameter int RUN_W   = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] remain,
  output logic [RUN_W-1:0] run_log
);
  // ascending scan: the last size that fits and is aligned wins
  always_comb begin
    run_log = '0;
    for (int i = 1; i <= RUN_MAX; i++) begin
      if ((32'(remain) >= (32'd1 << i)) &&
          ((32'(idx) & ((32'd1 << i) - 32'd1)) == 32'd0))
        run_log = RUN_W'(i);
    end
  end
endmodule

// File: rtl/ptf_tag_calc.sv
module ptf_tag_calc
  import ptf_pkg::*;
(
  input  logic [PTF_TAG_W-1:0] tag_base,
  input  logic [PTF_TAG_W-1:0] off_blk,
  input  logic [1:0]           factor,
  output logic [PTF_TAG_W-1:0] tag
);
  logic [PTF_TAG_W-1:0] scaled;

  always_comb begin
    scaled = off_blk * PTF_TAG_W'(factor);
    tag    = (factor != 2'd0) ? tag_base + scaled : '0;
  end
endmodule

// File: rtl/ptf_entry_fmt.sv
module ptf_entry_fmt
  import ptf_pkg::*;
(
  input  logic [PTF_PG_W-1:0]  page,
  input  logic [PTF_MT_W-1:0]  mtype,
  input  logic [1:0]           target,
  input  logic                 sys,
  input  logic                 wo,
  input  logic [PTF_RUN_W-1:0] run_log,
  input  logic [PTF_TAG_W-1:0] tag,
  output logic [31:0]          lo,
  output logic [31:0]          hi
);
  always_comb begin
    lo = {page[19:0], 2'b00, run_log, sys, target, ~wo, 2'b00, 1'b1};
    hi = {tag, mtype, page[PTF_PG_W-1:20]};
  end
endmodule

// File: rtl/pte_run_filler.sv
module pte_run_filler
  import ptf_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_mode,
  input  logic [IDX_W-1:0]     cmd_index,
  input  logic [CNT_W-1:0]     cmd_count,
  input  logic [PTF_PA_W-1:0]  cmd_phys,
  input  logic [PTF_MT_W-1:0]  cmd_mtype,
  input  logic [1:0]           cmd_target,
  input  logic                 cmd_sys,
  input  logic                 cmd_wo,
  input  logic                 cmd_nosnoop,
  input  logic                 cmd_page_big,
  input  logic [PTF_TAG_W-1:0] cmd_tag_base,
  input  logic [PTF_PA_W-1:0]  stolen_base,
  input  logic                 sg_valid,
  output logic                 sg_ready,
  input  logic [PTF_PG_W-1:0]  sg_page,
  output logic                 wr_en,
  output logic [IDX_W+2:0]     wr_addr,
  output logic [31:0]          wr_data,
  output logic                 done
);
  localparam int ADDR_W    = IDX_W + 3;
  localparam int RUN_LEN_W = PTF_RUN_MAX + 1;

  ptf_state_e              state;
  logic [1:0]              mode_q;
  logic [IDX_W-1:0]        idx_q;
  logic [CNT_W-1:0]        rem_q;
  logic [RUN_LEN_W-1:0]    run_left_q;
  logic [PTF_RUN_W-1:0]    run_log_q;
  logic [PTF_PA_W-1:0]     phys_q;
  logic [PTF_PA_W-1:0]     off_q;
  logic [PTF_MT_W-1:0]     mt_q;
  logic [1:0]              tgt_q;
  logic                    sys_q;
  logic                    wo_q;
  logic                    big_q;
  logic [PTF_TAG_W-1:0]    tagb_q;
  logic [31:0]             lo_q;
  logic [31:0]             hi_q;

  logic [PTF_RUN_W-1:0]    run_sel;
  logic [PTF_TAG_W-1:0]    tag_cur;
  logic [31:0]             map_lo, map_hi, sg_lo, sg_hi;
  logic [PTF_PA_W-1:0]     adv;
  logic                    is_map, is_sg;

  assign cmd_ready = (state == S_IDLE);
  assign sg_ready  = (state == S_SG);
  assign is_map    = (mode_q == PTF_MAP);
  assign is_sg     = (mode_q == PTF_SCATTER);
  assign adv       = PTF_PA_W'(1) << (5'(run_log_q) + (big_q ? 5'd16 : 5'd12));

  ptf_run_sizer #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .RUN_MAX(PTF_RUN_MAX), .RUN_W(PTF_RUN_W)
  ) u_sizer (
    .idx(idx_q), .remain(rem_q), .run_log(run_sel)
  );

  ptf_tag_calc u_tag (
    .tag_base(tagb_q),
    .off_blk (off_q[16 +: PTF_TAG_W]),
    .factor  (mt_q[8:7]),
    .tag     (tag_cur)
  );

  ptf_entry_fmt u_fmt_map (
    .page(phys_q[PTF_PA_W-1:12]), .mtype(mt_q), .target(tgt_q),
    .sys(sys_q), .wo(wo_q), .run_log(run_sel), .tag(tag_cur),
    .lo(map_lo), .hi(map_hi)
  );

  ptf_entry_fmt u_fmt_sg (
    .page(sg_page), .mtype(mt_q), .target(tgt_q),
    .sys(sys_q), .wo(wo_q), .run_log('0), .tag('0),
    .lo(sg_lo), .hi(sg_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mode_q     <= PTF_MAP;
      idx_q      <= '0;
      rem_q      <= '0;
      run_left_q <= '0;
      run_log_q  <= '0;
      phys_q     <= '0;
      off_q      <= '0;
      mt_q       <= '0;
      tgt_q      <= '0;
      sys_q      <= 1'b0;
      wo_q       <= 1'b0;
      big_q      <= 1'b0;
      tagb_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          mode_q     <= cmd_mode;
          idx_q      <= cmd_index;
          rem_q      <= cmd_count;
          off_q      <= '0;
          mt_q       <= cmd_mtype;
          sys_q      <= cmd_sys;
          wo_q       <= cmd_wo;
          big_q      <= cmd_page_big;
          tagb_q     <= cmd_tag_base;
          run_left_q <= RUN_LEN_W'(1);
          lo_q       <= '0;
          hi_q       <= '0;
          phys_q     <= (stolen_base != '0) ? cmd_phys + stolen_base : cmd_phys;
          if (cmd_mode == PTF_SCATTER)
            tgt_q <= cmd_nosnoop ? 2'd3 : 2'd2;
          else
            tgt_q <= (stolen_base != '0) ? 2'd3 : cmd_target;
          if (cmd_count == '0)
            done <= 1'b1;
          else if (cmd_mode == PTF_MAP)
            state <= S_RUN;
          else if (cmd_mode == PTF_SCATTER)
            state <= S_SG;
          else
            state <= S_LO;
        end
        S_RUN: begin
          run_log_q  <= run_sel;
          run_left_q <= RUN_LEN_W'(1) << run_sel;
          lo_q       <= map_lo;
          hi_q       <= map_hi;
          state      <= S_LO;
        end
        S_SG: if (sg_valid) begin
          lo_q  <= sg_lo;
          hi_q  <= sg_hi;
          state <= S_LO;
        end
        S_LO: begin
          wr_en   <= 1'b1;
          wr_addr <= {idx_q, 3'b000};
          wr_data <= lo_q;
          state   <= S_HI;
        end
        S_HI: begin
          wr_en      <= 1'b1;
          wr_addr    <= {idx_q, 3'b100};
          wr_data    <= hi_q;
          idx_q      <= idx_q + 1'b1;
          rem_q      <= rem_q - 1'b1;
          run_left_q <= run_left_q - 1'b1;
          if (is_map && run_left_q == RUN_LEN_W'(1)) begin
            phys_q <= phys_q + adv;
            off_q  <= off_q + adv;
          end
          if (rem_q == CNT_W'(1)) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (is_map)
            state <= (run_left_q == RUN_LEN_W'(1)) ? S_RUN : S_LO;
          else if (is_sg)
            state <= S_SG;
          else
            state <= S_LO;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  hi_follows_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[2]) |=> (wr_en && wr_addr[2] &&
      wr_addr[ADDR_W-1:3] == $past(wr_addr[ADDR_W-1:3])));

  // R3
  present_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[2] && mode_q != PTF_UNMAP) |-> wr_data[0]);

  // R4
  run_fit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) |-> ((32'(rem_q) >= (32'd1 << run_sel)) &&
      ((32'(idx_q) & ((32'd1 << run_sel) - 32'd1)) == 32'd0)));

  // R8
  sg_no_run_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[2] && mode_q == PTF_SCATTER) |-> (wr_data[9:7] == 3'd0));

  // R9
  unmap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode_q == PTF_UNMAP) |-> (wr_data == 32'd0));

  // R1
  done_alone_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == S_IDLE));
endmodule

// File: tb/pte_run_filler_bench.sv
`timescale 1ns/1ps
module pte_run_filler_bench;
  localparam int IDX_W = 16;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic               cmd_valid = 0, cmd_ready;
  logic [1:0]         cmd_mode = 0;
  logic [IDX_W-1:0]   cmd_index = 0;
  logic [CNT_W-1:0]   cmd_count = 0;
  logic [39:0]        cmd_phys = 0;
  logic [8:0]         cmd_mtype = 0;
  logic [1:0]         cmd_target = 0;
  logic               cmd_sys = 0, cmd_wo = 0, cmd_nosnoop = 0, cmd_page_big = 0;
  logic [14:0]        cmd_tag_base = 0;
  logic [39:0]        stolen_base = 0;
  logic               sg_valid = 0, sg_ready;
  logic [27:0]        sg_page = 0;
  logic               wr_en, done;
  logic [IDX_W+2:0]   wr_addr;
  logic [31:0]        wr_data;

  pte_run_filler #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_pte_run_filler (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_index(cmd_index), .cmd_count(cmd_count),
    .cmd_phys(cmd_phys), .cmd_mtype(cmd_mtype), .cmd_target(cmd_target),
    .cmd_sys(cmd_sys), .cmd_wo(cmd_wo), .cmd_nosnoop(cmd_nosnoop),
    .cmd_page_big(cmd_page_big), .cmd_tag_base(cmd_tag_base),
    .stolen_base(stolen_base), .sg_valid(sg_valid), .sg_ready(sg_ready),
    .sg_page(sg_page), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done)
  );

  int tests = 0, fails = 0, done_cnt = 0, cycles = 0;
  logic [IDX_W+2:0] ea_q[$];
  logic [31:0]      ed_q[$];
  string            er_q[$];
  logic [27:0]      sg_list[4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void push(input logic [IDX_W-1:0] idx, input logic [31:0] lo,
                               input logic [31:0] hi, input string req);
    ea_q.push_back({idx, 3'b000}); ed_q.push_back(lo); er_q.push_back(req);
    ea_q.push_back({idx, 3'b100}); ed_q.push_back(hi); er_q.push_back(req);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      if (wr_en) begin
        if (ea_q.size() == 0)
          check(0, "R1", "unexpected write", {45'd0, wr_addr}, 64'd0);
        else begin
          logic [IDX_W+2:0] a; logic [31:0] d; string r;
          a = ea_q.pop_front(); d = ed_q.pop_front(); r = er_q.pop_front();
          check(wr_addr == a, "R2", "word address", {45'd0, wr_addr}, {45'd0, a});
          check(wr_data == d, r, "word data", {32'd0, wr_data}, {32'd0, d});
        end
      end
      if (done) begin
        done_cnt++;
        check(ea_q.size() == 0, "R1", "done before last word",
              64'(ea_q.size()), 64'd0);
      end
      if (cycles > 100000) begin
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  // expected model for contiguous map (R3..R7)
  task automatic exp_map(input int idx0, input int cnt, input logic [39:0] phys,
                         input logic [8:0] mt, input logic [1:0] tgt, input bit sys,
                         input bit wo, input bit big, input logic [14:0] tagb,
                         input logic [39:0] stolen, input string req);
    logic [39:0] p, off;
    logic [1:0] t;
    logic [14:0] tag;
    logic [1:0] f;
    int idx, rem, lg, len;
    p = (stolen != 0) ? phys + stolen : phys;
    t = (stolen != 0) ? 2'd3 : tgt;
    f = mt[8:7];
    off = 0; idx = idx0; rem = cnt;
    while (rem > 0) begin
      lg = 7;
      while (lg > 0 && !(rem >= (1 << lg) && (idx % (1 << lg)) == 0)) lg--;
      len = 1 << lg;
      tag = (f != 0) ? 15'(tagb + 15'(off >> 16) * 15'(f)) : 15'd0;
      for (int k = 0; k < len; k++)
        push(IDX_W'(idx + k), {p[31:12], 2'b00, 3'(lg), sys, t, ~wo, 2'b00, 1'b1},
             {tag, mt, p[39:32]}, req);
      p   = p + (40'(len) << (big ? 16 : 12));
      off = off + (40'(len) << (big ? 16 : 12));
      idx += len; rem -= len;
    end
  endtask

  task automatic issue(input logic [1:0] mode, input int idx, input int cnt);
    @(negedge clk);
    cmd_mode = mode; cmd_index = IDX_W'(idx); cmd_count = CNT_W'(cnt);
    cmd_valid = 1;
    check(cmd_ready == 1, "R1", "ready when idle", {63'd0, cmd_ready}, 64'd1);
    @(negedge clk);
    cmd_valid = 0;
    if (cnt != 0)
      check(cmd_ready == 0, "R1", "busy blocks commands", {63'd0, cmd_ready}, 64'd0);
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_map(input int idx, input int cnt, input logic [39:0] phys,
                        input logic [8:0] mt, input logic [1:0] tgt, input bit sys,
                        input bit wo, input bit big, input logic [14:0] tagb,
                        input string req);
    int tgt_done;
    tgt_done = done_cnt + 1;
    exp_map(idx, cnt, phys, mt, tgt, sys, wo, big, tagb, stolen_base, req);
    cmd_phys = phys; cmd_mtype = mt; cmd_target = tgt; cmd_sys = sys;
    cmd_wo = wo; cmd_page_big = big; cmd_tag_base = tagb;
    issue(2'd0, idx, cnt);
    wait_done(tgt_done);
  endtask

  task automatic do_scatter(input int idx, input int n, input logic [8:0] mt,
                            input bit sys, input bit wo, input bit ns);
    int k, tgt_done;
    logic [1:0] t;
    t = ns ? 2'd3 : 2'd2;
    tgt_done = done_cnt + 1;
    for (int i = 0; i < n; i++)
      push(IDX_W'(idx + i), {sg_list[i][19:0], 2'b00, 3'b000, sys, t, ~wo, 2'b00, 1'b1},
           {15'd0, mt, sg_list[i][27:20]}, "R8");
    cmd_mtype = mt; cmd_sys = sys; cmd_wo = wo; cmd_nosnoop = ns; cmd_target = 2'd0;
    issue(2'd1, idx, n);
    k = 0;
    while (k < n) begin
      sg_valid = 1; sg_page = sg_list[k];
      if (sg_ready) k++;
      @(negedge clk);
    end
    sg_valid = 0;
    wait_done(tgt_done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready == 1 && wr_en == 0 && done == 0, "R1", "reset state",
          {61'd0, cmd_ready, wr_en, done}, 64'h4);
    rst = 0;

    // R4 R5 R3: 4 KiB runs of 1, 4, 8
    do_map(3, 13, 40'h12_3456_7000, 9'h012, 2'd0, 0, 0, 0, 15'd0, "R3 R4 R5");
    // R6: 64 KiB runs 128, 64, 8 with factor 3
    do_map(0, 200, 40'h80_0000_0000, 9'h1A5, 2'd1, 1, 1, 1, 15'h100, "R6");
    // R6: 4 KiB, factor 1, tag steps every 16 entries
    do_map(32, 40, 40'h00_4000_0000, 9'h0C0, 2'd2, 0, 0, 0, 15'h7FF0, "R6");
    // R7: carve-out base forces target 3
    stolen_base = 40'h00_1000_0000;
    do_map(100, 6, 40'h00_0002_0000, 9'h003, 2'd1, 1, 0, 0, 15'd0, "R7");
    stolen_base = 0;

    // R8: scatter without and with no-snoop
    sg_list[0] = 28'h000_1234; sg_list[1] = 28'hABC_DEF0;
    sg_list[2] = 28'h000_0001; sg_list[3] = 28'h800_0000;
    do_scatter(7, 3, 9'h185, 1, 0, 0);
    do_scatter(64, 4, 9'h011, 0, 1, 1);

    // R9: unmap
    begin
      int td;
      td = done_cnt + 1;
      for (int i = 0; i < 5; i++) push(IDX_W'(2 + i), 32'd0, 32'd0, "R9");
      issue(2'd2, 2, 5);
      wait_done(td);
    end

    // R1: zero count completes in the next cycle with no writes
    @(negedge clk);
    cmd_mode = 2'd0; cmd_count = 0; cmd_index = 16'd9; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    check(done == 1 && wr_en == 0, "R1", "zero count done",
          {62'd0, done, wr_en}, 64'h2);
    repeat (4) @(negedge clk);
    check(ea_q.size() == 0, "R2", "all words written", 64'(ea_q.size()), 64'd0);
    check(done_cnt == 8, "R1", "done pulse count", 64'(done_cnt), 64'd8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule